// File: doc/BRIEF.md
# Fixed-Head Disk Command Decoder

This block sits on the I/O bus of a 12-bit processor. It decodes the programmed I/O instructions aimed at a fixed-head disk controller. A six-bit device selector picks one of four controller groups, and the three low instruction bits pick the operation. Each instruction runs over up to three timing pulses, in the order phase 1, phase 2 and phase 4. Each operation spreads its work over those pulses: a clear in one, a load in another, and the accumulator clear or readback where the operation calls for it.

The block holds the controller's programmer-visible state:
- a 12-bit disk address and an 8-bit extension, which together form a 20-bit disk position;
- three interrupt enables and a 3-bit memory-extension field;
- the latched data-late, parity and completion flags.

It drives the accumulator clear and load strobes, the readback value, the skip line, the read and write start pulses and the system-clear pulse. It also drives a level interrupt request. The transfer engine reports back through these inputs:
- pulses: data late, parity error, transfer complete, and one pulse per word moved;
- levels: photocell, data request enable, write lock, nonexistent disk, and the current word position under the heads.

Top module: `fhd_cmd_decoder`

## Requirements
- R1: After reset the disk address, extension, enables, memory-extension field and all latched flags are zero. With `iot` low, every strobe and `skip` is low and `ac_out` is zero.
- R2: Group 60 operations 1, 3 and 5 pulse `sys_clear` at phase 1. That pulse clears the 12-bit disk address and the data-late, parity and completion flags. It leaves the extension, the enables and the memory-extension field unchanged.
- R3: Group 60 operation 3 loads the disk address from `ac_in` at phase 2, asserts `ac_clear` and pulses `rd_start` in that same cycle.
- R4: Group 60 operation 5 loads the disk address from `ac_in` at phase 4, asserts `ac_clear` and pulses `wr_start` in that same cycle.
- R5: Group 61 operation 1 clears the enables and the memory-extension field at phase 1. Group 61 operation 5 clears them at phase 1. At phase 4 it then loads error enable from AC bit 8, photocell enable from bit 7, completion enable from bit 6 and the memory-extension field from bits 5:3, and asserts `ac_clear`.
- R6: Group 61 operation 2 asserts `ac_clear` at phase 2. In that cycle `skip` is high exactly when the 12-bit disk address equals `word_pos`.
- R7: At phase 2, group 62 skips as follows. Operation 1 skips on error, which is data late, parity, write lock or nonexistent disk. Operation 2 skips on completion. Operation 3 skips on either.
- R8: Group 61 operation 6 asserts `ac_clear` at phase 2. At phase 4 it asserts `ac_load` with this status word: bit 11 photocell, bit 10 data request enable, bit 9 write lock, bit 8 error enable, bit 7 photocell enable, bit 6 completion enable, bits 5:3 memory extension, bit 2 data late, bit 1 nonexistent disk, bit 0 parity.
- R9: Group 62 operation 6 clears AC at phase 2 and loads the disk address at phase 4. Group 64 operation 5 does the same with the zero-extended extension. Group 64 operation 1 clears the extension at phase 1. Group 64 operation 3 clears it at phase 1, then loads it from `ac_in[7:0]` at phase 2 with `ac_clear`.
- R10: `irq` is high whenever any of these holds: error with error enable, completion with completion enable, or photocell with photocell enable.
- R11: `word_step` increments the 20-bit value {extension, address}, wrapping to zero. The step is dropped in any cycle that clears or loads either half.
- R12: The late, parity and completion event pulses set their flags. When an event pulse and `sys_clear` arrive in the same cycle, the set wins.
- R13: Nothing happens without `iot`, or with a selector outside the four groups: no strobe, no skip, no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iot | input | 1 | I/O instruction in progress |
| dev_sel | input | 6 | Device selector |
| op_bits | input | 3 | Operation bits |
| iop1 | input | 1 | Phase 1 pulse |
| iop2 | input | 1 | Phase 2 pulse |
| iop4 | input | 1 | Phase 4 pulse |
| ac_in | input | 12 | Accumulator contents |
| photocell | input | 1 | Photocell status level |
| dre_in | input | 1 | Data request enable level |
| write_lock | input | 1 | Write lock level |
| nxd | input | 1 | Nonexistent disk level |
| late_evt | input | 1 | Data-late event pulse |
| parity_evt | input | 1 | Parity error event pulse |
| done_evt | input | 1 | Transfer complete pulse |
| word_step | input | 1 | One word moved pulse |
| word_pos | input | 12 | Current disk word position |
| ac_out | output | 12 | Readback value, zero unless loading |
| ac_load | output | 1 | Load AC from ac_out |
| ac_clear | output | 1 | Clear AC |
| skip | output | 1 | Skip request |
| rd_start | output | 1 | Start read transfer |
| wr_start | output | 1 | Start write transfer |
| sys_clear | output | 1 | Controller system clear pulse |
| irq | output | 1 | Interrupt request |
| disk_addr | output | 20 | {extension, address} |

## Verification
The bench aims at the phase placement of each operation. A decoder that loaded the address at the wrong pulse shows the wrong `disk_addr` one cycle early or late. One that cleared the enables during a system clear loses `irq`. The carry from `0xFFFFF` back to zero and a step that coincides with a command are both driven; a design that stepped on top of a load would leave the address one too high. An event pulse is also sent alongside a system clear, where a clear-wins flag would drop a real error. The bench also covers skip on an unmatched word position and commands with an out-of-range selector.

// File: rtl/fhd_pkg.sv
package fhd_pkg;

    localparam int AC_W  = 12;
    localparam int EXT_W = 8;
    localparam int MEX_W = 3;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_STATUS,
        SRC_ADDR,
        SRC_EXT
    } ac_src_e;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_MATCH,
        SK_ERR,
        SK_DONE,
        SK_ANY
    } skip_sel_e;

    typedef struct packed {
        logic      sys_clr;
        logic      ld_addr;
        logic      start_rd;
        logic      start_wr;
        logic      clr_en;
        logic      ld_en;
        logic      clr_ext;
        logic      ld_ext;
        logic      ac_clr;
        ac_src_e   src;
        skip_sel_e sk;
    } action_t;

    typedef struct packed {
        logic             eie;
        logic             pie;
        logic             cie;
        logic [MEX_W-1:0] mex;
    } enables_t;

    typedef struct packed {
        logic late;
        logic par;
        logic done;
    } flags_t;

    function automatic logic [AC_W-1:0] pack_status(
        input logic     pc,
        input logic     dre,
        input logic     wl,
        input enables_t en,
        input flags_t   fl,
        input logic     nx
    );
        return {pc, dre, wl, en.eie, en.pie, en.cie, en.mex, fl.late, nx, fl.par};
    endfunction

endpackage

// File: rtl/fhd_cmd_decode.sv
module fhd_cmd_decode
    import fhd_pkg::*;
#(
    parameter logic [5:0] DEV_XFER = 6'o60,
    parameter logic [5:0] DEV_INTR = 6'o61,
    parameter logic [5:0] DEV_STAT = 6'o62,
    parameter logic [5:0] DEV_EXTA = 6'o64
) (
    input  logic       iot,
    input  logic [5:0] dev_sel,
    input  logic [2:0] op_bits,
    input  logic       iop1,
    input  logic       iop2,
    input  logic       iop4,
    output action_t    act
);

    logic p1, p2, p4;
    assign p1 = iot & iop1;
    assign p2 = iot & iop2;
    assign p4 = iot & iop4;

    always_comb begin
        act = '0;
        act.src = SRC_NONE;
        act.sk  = SK_NONE;
        unique case (dev_sel)
            DEV_XFER: begin
                // R2: system clear at phase 1
                if (p1 && (op_bits == 3'd1 || op_bits == 3'd3 || op_bits == 3'd5))
                    act.sys_clr = 1'b1;
                // R3: read load at phase 2
                if (p2 && op_bits == 3'd3) begin
                    act.ld_addr  = 1'b1;
                    act.ac_clr   = 1'b1;
                    act.start_rd = 1'b1;
                end
                // R4: write load at phase 4
                if (p4 && op_bits == 3'd5) begin
                    act.ld_addr  = 1'b1;
                    act.ac_clr   = 1'b1;
                    act.start_wr = 1'b1;
                end
            end
            DEV_INTR: begin
                // R5
                if (p1 && (op_bits == 3'd1 || op_bits == 3'd5))
                    act.clr_en = 1'b1;
                if (p4 && op_bits == 3'd5) begin
                    act.ld_en  = 1'b1;
                    act.ac_clr = 1'b1;
                end
                // R6
                if (p2 && op_bits == 3'd2) begin
                    act.sk     = SK_MATCH;
                    act.ac_clr = 1'b1;
                end
                // R8
                if (p2 && op_bits == 3'd6)
                    act.ac_clr = 1'b1;
                if (p4 && op_bits == 3'd6)
                    act.src = SRC_STATUS;
            end
            DEV_STAT: begin
                // R7
                if (p2) begin
                    case (op_bits)
                        3'd1:    act.sk = SK_ERR;
                        3'd2:    act.sk = SK_DONE;
                        3'd3:    act.sk = SK_ANY;
                        default: act.sk = SK_NONE;
                    endcase
                end
                // R9
                if (p2 && op_bits == 3'd6)
                    act.ac_clr = 1'b1;
                if (p4 && op_bits == 3'd6)
                    act.src = SRC_ADDR;
            end
            DEV_EXTA: begin
                // R9
                if (p1 && (op_bits == 3'd1 || op_bits == 3'd3))
                    act.clr_ext = 1'b1;
                if (p2 && op_bits == 3'd3) begin
                    act.ld_ext = 1'b1;
                    act.ac_clr = 1'b1;
                end
                if (p2 && op_bits == 3'd5)
                    act.ac_clr = 1'b1;
                if (p4 && op_bits == 3'd5)
                    act.src = SRC_EXT;
            end
            default: begin
                // R13: foreign selector, no action
            end
        endcase
    end

endmodule

// File: rtl/fhd_addr_regs.sv
module fhd_addr_regs
    import fhd_pkg::*;
#(
    parameter int ADDR_W = AC_W,
    parameter int EXTW   = EXT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  action_t           act,
    input  logic [AC_W-1:0]   ac_in,
    input  logic              word_step,
    output logic [ADDR_W-1:0] addr_q,
    output logic [EXTW-1:0]   ext_q
);

    localparam int FULL_W = ADDR_W + EXTW;

    logic              touch;
    logic [FULL_W-1:0] stepped;

    // R11: any write to either half suppresses the step
    assign touch   = act.sys_clr | act.ld_addr | act.clr_ext | act.ld_ext;
    assign stepped = {ext_q, addr_q} + FULL_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ext_q  <= '0;
        end else begin
            if (act.ld_addr)
                addr_q <= ADDR_W'(ac_in);
            else if (act.sys_clr)
                addr_q <= '0;
            else if (word_step && !touch)
                addr_q <= stepped[ADDR_W-1:0];

            if (act.ld_ext)
                ext_q <= ac_in[EXTW-1:0];
            else if (act.clr_ext)
                ext_q <= '0;
            else if (word_step && !touch)
                ext_q <= stepped[FULL_W-1:ADDR_W];
        end
    end

endmodule

// File: rtl/fhd_status_regs.sv
module fhd_status_regs
    import fhd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  action_t         act,
    input  logic [AC_W-1:0] ac_in,
    input  logic            late_evt,
    input  logic            parity_evt,
    input  logic            done_evt,
    input  logic            write_lock,
    input  logic            nxd,
    input  logic            photocell,
    output enables_t        en_q,
    output flags_t          fl_q,
    output logic            err,
    output logic            irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            fl_q <= '0;
        end else begin
            // R5
            if (act.ld_en) begin
                en_q.eie <= ac_in[8];
                en_q.pie <= ac_in[7];
                en_q.cie <= ac_in[6];
                en_q.mex <= ac_in[5:3];
            end else if (act.clr_en) begin
                en_q <= '0;
            end
            // R12: event set wins over system clear
            if (late_evt)         fl_q.late <= 1'b1;
            else if (act.sys_clr) fl_q.late <= 1'b0;
            if (parity_evt)       fl_q.par  <= 1'b1;
            else if (act.sys_clr) fl_q.par  <= 1'b0;
            if (done_evt)         fl_q.done <= 1'b1;
            else if (act.sys_clr) fl_q.done <= 1'b0;
        end
    end

    assign err = fl_q.late | fl_q.par | write_lock | nxd;
    // R10
    assign irq = (err & en_q.eie) | (fl_q.done & en_q.cie) | (photocell & en_q.pie);

endmodule

// File: rtl/fhd_cmd_decoder.sv
module fhd_cmd_decoder
    import fhd_pkg::*;
#(
    parameter logic [5:0] DEV_XFER = 6'o60,
    parameter logic [5:0] DEV_INTR = 6'o61,
    parameter logic [5:0] DEV_STAT = 6'o62,
    parameter logic [5:0] DEV_EXTA = 6'o64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        iot,
    input  logic [5:0]  dev_sel,
    input  logic [2:0]  op_bits,
    input  logic        iop1,
    input  logic        iop2,
    input  logic        iop4,
    input  logic [11:0] ac_in,
    input  logic        photocell,
    input  logic        dre_in,
    input  logic        write_lock,
    input  logic        nxd,
    input  logic        late_evt,
    input  logic        parity_evt,
    input  logic        done_evt,
    input  logic        word_step,
    input  logic [11:0] word_pos,
    output logic [11:0] ac_out,
    output logic        ac_load,
    output logic        ac_clear,
    output logic        skip,
    output logic        rd_start,
    output logic        wr_start,
    output logic        sys_clear,
    output logic        irq,
    output logic [19:0] disk_addr
);

    action_t            act;
    logic [AC_W-1:0]    addr_q;
    logic [EXT_W-1:0]   ext_q;
    enables_t           en_q;
    flags_t             fl_q;
    logic               err;

    fhd_cmd_decode #(
        .DEV_XFER(DEV_XFER), .DEV_INTR(DEV_INTR),
        .DEV_STAT(DEV_STAT), .DEV_EXTA(DEV_EXTA)
    ) u_dec (
        .iot(iot), .dev_sel(dev_sel), .op_bits(op_bits),
        .iop1(iop1), .iop2(iop2), .iop4(iop4), .act(act)
    );

    fhd_addr_regs #(.ADDR_W(AC_W), .EXTW(EXT_W)) u_addr (
        .clk(clk), .rst(rst), .act(act), .ac_in(ac_in),
        .word_step(word_step), .addr_q(addr_q), .ext_q(ext_q)
    );

    fhd_status_regs u_stat (
        .clk(clk), .rst(rst), .act(act), .ac_in(ac_in),
        .late_evt(late_evt), .parity_evt(parity_evt), .done_evt(done_evt),
        .write_lock(write_lock), .nxd(nxd), .photocell(photocell),
        .en_q(en_q), .fl_q(fl_q), .err(err), .irq(irq)
    );

    // R8, R9: readback source
    always_comb begin
        ac_out = '0;
        case (act.src)
            SRC_STATUS: ac_out = pack_status(photocell, dre_in, write_lock, en_q, fl_q, nxd);
            SRC_ADDR:   ac_out = addr_q;
            SRC_EXT:    ac_out = {{(AC_W-EXT_W){1'b0}}, ext_q};
            default:    ac_out = '0;
        endcase
    end

    // R6, R7: skip selection
    always_comb begin
        case (act.sk)
            SK_MATCH: skip = (addr_q == word_pos);
            SK_ERR:   skip = err;
            SK_DONE:  skip = fl_q.done;
            SK_ANY:   skip = err | fl_q.done;
            default:  skip = 1'b0;
        endcase
    end

    assign ac_load   = (act.src != SRC_NONE);
    assign ac_clear  = act.ac_clr;
    assign rd_start  = act.start_rd;
    assign wr_start  = act.start_wr;
    assign sys_clear = act.sys_clr;
    assign disk_addr = {ext_q, addr_q};

endmodule

// File: rtl/fhd_cmd_decoder_chk.sv
module fhd_cmd_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        iot,
    input logic        iop4,
    input logic [11:0] ac_in,
    input logic        word_step,
    input logic        ac_load,
    input logic        ac_clear,
    input logic        skip,
    input logic        rd_start,
    input logic        wr_start,
    input logic        sys_clear,
    input logic [19:0] disk_addr
);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !iot |-> !(skip | ac_load | ac_clear | sys_clear | rd_start | wr_start));

    // R4
    one_start_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_start && wr_start));

    // R2
    sysclr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        sys_clear |=> disk_addr[11:0] == 12'd0);

    // R3
    rd_load_chk: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> disk_addr[11:0] == $past(ac_in));

    // R3
    rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> ac_clear);

    // R11
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (word_step && !iot) |=> disk_addr == 20'($past(disk_addr) + 20'd1));

    // R8
    load_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ac_load |-> iop4);

endmodule

bind fhd_cmd_decoder fhd_cmd_decoder_chk u_chk (
    .clk(clk), .rst(rst), .iot(iot), .iop4(iop4), .ac_in(ac_in),
    .word_step(word_step), .ac_load(ac_load), .ac_clear(ac_clear),
    .skip(skip), .rd_start(rd_start), .wr_start(wr_start),
    .sys_clear(sys_clear), .disk_addr(disk_addr)
);

// File: tb/tb_fhd_cmd_decoder.sv
module tb_fhd_cmd_decoder;

    logic clk = 0;
    logic rst = 1;
    logic iot = 0;
    logic [5:0] dev_sel = 0;
    logic [2:0] op_bits = 0;
    logic iop1 = 0, iop2 = 0, iop4 = 0;
    logic [11:0] ac_in = 0;
    logic photocell = 0, dre_in = 0, write_lock = 0, nxd = 0;
    logic late_evt = 0, parity_evt = 0, done_evt = 0, word_step = 0;
    logic [11:0] word_pos = 0;
    logic [11:0] ac_out;
    logic ac_load, ac_clear, skip, rd_start, wr_start, sys_clear, irq;
    logic [19:0] disk_addr;

    always #2 clk = ~clk;

    fhd_cmd_decoder dut (.*);

    int total = 0, bad = 0, cycles = 0;
    string cur_req = "R1";

    // reference state
    int m_addr = 0, m_ext = 0, m_mex = 0;
    bit m_eie = 0, m_pie = 0, m_cie = 0, m_late = 0, m_par = 0, m_done = 0;
    int n_addr, n_ext, n_mex;
    bit n_eie, n_pie, n_cie, n_late, n_par, n_done;
    int e_acout;
    bit e_load, e_clr, e_skip, e_rd, e_wr, e_sys, e_irq;

    task automatic model_eval();
        bit p1, p2, p4, err, touch;
        int d, o, full;
        p1 = iot && iop1; p2 = iot && iop2; p4 = iot && iop4;
        d = dev_sel; o = op_bits;
        err = m_late || m_par || write_lock || nxd;
        e_sys = (d == 'o60) && p1 && (o == 1 || o == 3 || o == 5);
        e_rd  = (d == 'o60) && p2 && o == 3;
        e_wr  = (d == 'o60) && p4 && o == 5;
        e_clr = e_rd || e_wr || ((d == 'o61) && p4 && o == 5) || ((d == 'o64) && p2 && o == 3)
              || ((d == 'o61) && p2 && (o == 2 || o == 6)) || ((d == 'o62) && p2 && o == 6)
              || ((d == 'o64) && p2 && o == 5);
        e_load = 0; e_acout = 0;
        if ((d == 'o61) && p4 && o == 6) begin
            e_load = 1;
            e_acout = (int'(photocell) << 11) | (int'(dre_in) << 10) | (int'(write_lock) << 9)
                    | (int'(m_eie) << 8) | (int'(m_pie) << 7) | (int'(m_cie) << 6) | (m_mex << 3)
                    | (int'(m_late) << 2) | (int'(nxd) << 1) | int'(m_par);
        end
        if ((d == 'o62) && p4 && o == 6) begin e_load = 1; e_acout = m_addr; end
        if ((d == 'o64) && p4 && o == 5) begin e_load = 1; e_acout = m_ext; end
        e_skip = 0;
        if ((d == 'o61) && p2 && o == 2) e_skip = (m_addr == int'(word_pos));
        if ((d == 'o62) && p2) begin
            if (o == 1) e_skip = err;
            if (o == 2) e_skip = m_done;
            if (o == 3) e_skip = err || m_done;
        end
        e_irq = (err && m_eie) || (m_done && m_cie) || (photocell && m_pie);
        // next state
        n_addr = m_addr; n_ext = m_ext;
        touch = e_sys || e_rd || e_wr || ((d == 'o64) && (p1 || p2) && (o == 1 || o == 3) && !(p2 && o == 1));
        if (e_rd || e_wr) n_addr = int'(ac_in);
        else if (e_sys) n_addr = 0;
        if ((d == 'o64) && p2 && o == 3) n_ext = int'(ac_in) & 'hFF;
        else if ((d == 'o64) && p1 && (o == 1 || o == 3)) n_ext = 0;
        if (word_step && !touch) begin
            full = ((m_ext << 12) | m_addr) + 1;
            full = full & 'hFFFFF;
            n_addr = full & 'hFFF; n_ext = full >> 12;
        end
        n_eie = m_eie; n_pie = m_pie; n_cie = m_cie; n_mex = m_mex;
        if ((d == 'o61) && p4 && o == 5) begin
            n_eie = ac_in[8]; n_pie = ac_in[7]; n_cie = ac_in[6]; n_mex = int'(ac_in[5:3]);
        end else if ((d == 'o61) && p1 && (o == 1 || o == 5)) begin
            n_eie = 0; n_pie = 0; n_cie = 0; n_mex = 0;
        end
        n_late = late_evt ? 1 : (e_sys ? 0 : m_late);
        n_par  = parity_evt ? 1 : (e_sys ? 0 : m_par);
        n_done = done_evt ? 1 : (e_sys ? 0 : m_done);
    endtask

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        model_eval();
        chk("ac_out", int'(ac_out), e_acout);
        chk("ac_load", int'(ac_load), int'(e_load));
        chk("ac_clear", int'(ac_clear), int'(e_clr));
        chk("skip", int'(skip), int'(e_skip));
        chk("rd_start", int'(rd_start), int'(e_rd));
        chk("wr_start", int'(wr_start), int'(e_wr));
        chk("sys_clear", int'(sys_clear), int'(e_sys));
        chk("irq", int'(irq), int'(e_irq));
        chk("disk_addr", int'(disk_addr), (m_ext << 12) | m_addr);
    end

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_addr = 0; m_ext = 0; m_mex = 0; m_eie = 0; m_pie = 0; m_cie = 0;
            m_late = 0; m_par = 0; m_done = 0;
        end else begin
            m_addr = n_addr; m_ext = n_ext; m_mex = n_mex; m_eie = n_eie; m_pie = n_pie;
            m_cie = n_cie; m_late = n_late; m_par = n_par; m_done = n_done;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        iop1 = 0; iop2 = 0; iop4 = 0;
        late_evt = 0; parity_evt = 0; done_evt = 0; word_step = 0;
    endtask

    task automatic cmd(input logic [5:0] d, input logic [2:0] o, input logic [11:0] a);
        tick(); iot = 1; dev_sel = d; op_bits = o; ac_in = a; iop1 = 1;
        tick(); iop2 = 1;
        tick(); iop4 = 1;
        tick(); iot = 0;
    endtask

    initial begin
        repeat (3) tick();
        cur_req = "R1";
        rst = 0;
        tick(); tick();
        cur_req = "R3"; cmd(6'o60, 3'd3, 12'o1234);
        cur_req = "R11";
        tick(); word_step = 1; tick(); word_step = 1; tick();
        cur_req = "R6"; word_pos = 12'o1236; cmd(6'o61, 3'd2, 12'o7);
        word_pos = 12'o0001; cmd(6'o61, 3'd2, 12'o7);
        cur_req = "R7"; cmd(6'o62, 3'd1, 0); cmd(6'o62, 3'd3, 0);
        cur_req = "R12"; tick(); late_evt = 1; tick();
        cur_req = "R7"; cmd(6'o62, 3'd1, 0); cmd(6'o62, 3'd2, 0);
        tick(); done_evt = 1; tick(); cmd(6'o62, 3'd2, 0);
        cur_req = "R5"; cmd(6'o61, 3'd5, 12'o0750);
        cur_req = "R10"; tick(); photocell = 1; tick(); tick(); photocell = 0; tick();
        cur_req = "R8"; dre_in = 1; nxd = 1; write_lock = 1; cmd(6'o61, 3'd6, 0);
        dre_in = 0; nxd = 0; write_lock = 0;
        cur_req = "R2"; cmd(6'o60, 3'd1, 0);
        cur_req = "R12";
        tick(); iot = 1; dev_sel = 6'o60; op_bits = 3'd1; iop1 = 1; parity_evt = 1;
        tick(); iot = 0;
        cur_req = "R10"; tick(); parity_evt = 1; tick(); tick();
        cur_req = "R4"; cmd(6'o60, 3'd5, 12'o7777);
        cur_req = "R9"; cmd(6'o64, 3'd3, 12'o0377); cmd(6'o62, 3'd6, 0); cmd(6'o64, 3'd5, 0);
        cur_req = "R11"; tick(); word_step = 1; tick(); tick();
        cur_req = "R11";
        tick(); iot = 1; dev_sel = 6'o64; op_bits = 3'd3; ac_in = 12'o0012; iop1 = 1; word_step = 1;
        tick(); iop2 = 1; word_step = 1; tick(); iot = 0; tick();
        cur_req = "R9"; cmd(6'o64, 3'd1, 0);
        cur_req = "R5"; cmd(6'o61, 3'd1, 0);
        cur_req = "R13"; cmd(6'o63, 3'd3, 12'o5555); cmd(6'o65, 3'd5, 12'o1111);
        tick(); dev_sel = 6'o60; op_bits = 3'd3; iop1 = 1; tick(); iop2 = 1; tick(); tick();
        cur_req = "R1"; rst = 1; tick(); tick(); rst = 0; tick(); tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule